// File: doc/BRIEF.md
# Serial Character Boundary Framer

This block sits behind a clock and data recovery stage and turns a raw serial bit stream into aligned 10-bit characters. Each bit arrives with a bit-rate enable. The block looks for a comma at every bit position. When it accepts a comma at a position that differs from the boundary in use, it moves its character boundary there. It issues one character strobe for every ten enabled bits, with the character placed so that the first bit received is the most significant.

The comparator works in one of two patterns. The short pattern is the 7-bit comma in either polarity, with the last three bits ignored. The full pattern is the complete K28.5 character in either running disparity. The block also has two acceptance policies. In single-detect mode the boundary moves on the first comma seen at a new alignment, which gives the lowest latency. In multi-detect mode a comma at a new alignment only becomes a candidate. The boundary moves only when a second comma lands on the same alignment while both characters still fit inside a 50-bit span. A stray bit pattern that looks like a comma therefore cannot pull the boundary away. Framing can be switched off, and the boundary then stays where it is.

Top module: `sbf_framer`

## Requirements
- R1: After synchronous reset, char_out is 0, char_stb is 0 and realign is 0. The boundary counter restarts, so the first strobe follows the tenth enabled bit.
- R2: char_stb pulses for one cycle, in the cycle after every tenth enabled bit counted from the current boundary. char_out then holds those ten bits, with the first received bit in char_out[9] and the last in char_out[0]. Cycles with bit_en low change nothing and never strobe.
- R3: When full_pat is 0, a match is the last ten received bits (first bit leftmost) equal to 0011111xxx or 1100000xxx, where x is any value.
- R4: When full_pat is 1, a match is exactly 0011111010 or 1100000101. The 7-bit comma followed by other trailing bits is not a match.
- R5: When multi_mode is 0 and a match ends on a bit that is not a boundary bit, the boundary moves. In the cycle after that bit, realign and char_stb are both 1 and char_out holds the matched comma. Later strobes follow every tenth bit after it.
- R6: A match whose last bit is a boundary bit causes no realign pulse and leaves the strobe spacing unchanged.
- R7: When multi_mode is 1, the first match at a new alignment does not move the boundary. A second match at the same alignment, ending at most 40 enabled bits after the first so that both lie in a 50-bit span, moves the boundary as in R5.
- R8: When multi_mode is 1 and no second match at the same alignment arrives within 40 enabled bits, the candidate is discarded. A later match then starts a new candidate and does not realign.
- R9: While frame_en is 0, no match is taken, realign stays 0 and strobes keep the existing boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Next serial bit, in transmission order |
| frame_en | input | 1 | Allows the boundary to move when high |
| multi_mode | input | 1 | 0 selects single-detect, 1 selects multi-detect |
| full_pat | input | 1 | 0 selects the short comma, 1 selects the full K28.5 |
| char_out | output | 10 | Last aligned character, first received bit in bit 9 |
| char_stb | output | 1 | One-cycle pulse when char_out is updated |
| realign | output | 1 | One-cycle pulse when the boundary moves |

## Verification
Every output is registered once behind the bit that causes it. For any bit presented with bit_en, char_stb, char_out and realign show that bit's effect in the next cycle and hold it for one cycle. The bench drives each bit on a falling edge and reads the outputs a quarter period after the following rising edge, so each sample belongs to exactly one bit. It also samples during idle cycles, to show that nothing strobes without an enabled bit. The multi-detect cases place the second comma exactly 40 bits after the first, where it must be accepted, and exactly 50 bits after, where it must not be.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int CHAR_W    = 10;
    localparam int SHORT_LSB = 3;

    localparam logic [CHAR_W-1:0] COMMA_POS = 10'b0011111010;
    localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b1100000101;

    typedef enum logic {
        SCAN_SINGLE = 1'b0,
        SCAN_MULTI  = 1'b1
    } scan_mode_e;

    function automatic logic care_bit(input int idx, input logic full);
        return full || (idx >= SHORT_LSB);
    endfunction

endpackage

// File: rtl/sbf_shifter.sv
module sbf_shifter
    import sbf_pkg::*;
#(
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          bit_in,
    output logic [CW-1:0] win_next
);

    logic [CW-2:0] hist;

    assign win_next = {hist, bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (bit_en) begin
            hist <= win_next[CW-2:0];
        end
    end

endmodule

// File: rtl/sbf_match.sv
module sbf_match
    import sbf_pkg::*;
#(
    parameter int CW = CHAR_W
) (
    input  logic [CW-1:0] word,
    input  logic          en,
    input  logic          full_sel,
    output logic          hit
);

    logic [CW-1:0] eq_pos;
    logic [CW-1:0] eq_neg;

    for (genvar i = 0; i < CW; i++) begin : g_bit
        logic care;
        assign care      = care_bit(i, full_sel);
        assign eq_pos[i] = !care || (word[i] == COMMA_POS[i]);
        assign eq_neg[i] = !care || (word[i] == COMMA_NEG[i]);
    end

    assign hit = en && ((&eq_pos) || (&eq_neg));

endmodule

// File: rtl/sbf_bound.sv
module sbf_bound
    import sbf_pkg::*;
#(
    parameter int CW       = CHAR_W,
    parameter int WIN_BITS = 50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          hit,
    input  logic          frame_en,
    input  logic          multi_mode,
    input  logic [CW-1:0] win_next,
    output logic [CW-1:0] char_out,
    output logic          char_stb,
    output logic          realign
);

    localparam int LIM = WIN_BITS - CW;
    localparam int CNW = $clog2(CW);
    localparam int AGW = $clog2(LIM + 2);

    typedef struct packed {
        logic           valid;
        logic [CNW-1:0] phase;
        logic [AGW-1:0] age;
    } cand_t;

    scan_mode_e     mode;
    logic [CNW-1:0] cnt;
    cand_t          cand;
    logic           at_bnd;
    logic           same_ph;
    logic [AGW-1:0] age_p1;
    logic           take;
    logic           stb_now;

    assign mode    = scan_mode_e'(multi_mode);
    assign at_bnd  = (cnt == CNW'(CW - 1));
    assign age_p1  = cand.age + 1'b1;
    assign same_ph = cand.valid && (cand.phase == cnt) && (age_p1 <= AGW'(LIM));

    always_comb begin
        take = 1'b0;
        if (hit && !at_bnd) begin
            take = (mode == SCAN_SINGLE) || same_ph;
        end
    end

    assign stb_now = bit_en && (at_bnd || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            char_out <= '0;
            char_stb <= 1'b0;
            realign  <= 1'b0;
        end else begin
            char_stb <= stb_now;
            realign  <= bit_en && take;
            if (stb_now) begin
                char_out <= win_next;
            end
            if (bit_en) begin
                cnt <= (at_bnd || take) ? '0 : cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode == SCAN_SINGLE || !frame_en) begin
            cand <= '0;
        end else if (bit_en) begin
            if (take) begin
                cand <= '0;
            end else if (hit && !at_bnd) begin
                cand.valid <= 1'b1;
                cand.phase <= cnt;
                cand.age   <= '0;
            end else if (cand.valid) begin
                if (age_p1 >= AGW'(LIM)) begin
                    cand.valid <= 1'b0;
                end else begin
                    cand.age <= age_p1;
                end
            end
        end
    end

    // R2: a strobe always follows an enabled bit
    p_stb_after_bit_r2: assert property (@(posedge clk) disable iff (rst)
        char_stb |-> $past(bit_en));

    // R5: a moved boundary always presents the comma
    p_realign_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        realign |-> char_stb);

    // R5: single-detect moves on the first off-boundary match
    p_single_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && !at_bnd && !multi_mode) |=> realign);

    // R6: a match on the current boundary stays quiet
    p_on_boundary_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && at_bnd) |=> !realign);

    // R7: a first candidate in multi-detect never moves the boundary
    p_multi_first_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && !at_bnd && multi_mode && !cand.valid) |=> !realign);

    // R8: a held candidate is always younger than the window
    p_window_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cand.valid |-> (cand.age < AGW'(LIM)));

    // R9: no move unless framing was enabled
    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (rst)
        realign |-> $past(frame_en));

endmodule

// File: rtl/sbf_framer.sv
module sbf_framer
    import sbf_pkg::*;
#(
    parameter int CW       = CHAR_W,
    parameter int WIN_BITS = 50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic          frame_en,
    input  logic          multi_mode,
    input  logic          full_pat,
    output logic [CW-1:0] char_out,
    output logic          char_stb,
    output logic          realign
);

    logic [CW-1:0] win_next;
    logic          hit;

    sbf_shifter #(.CW(CW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    sbf_match #(.CW(CW)) u_match (
        .word     (win_next),
        .en       (bit_en && frame_en),
        .full_sel (full_pat),
        .hit      (hit)
    );

    sbf_bound #(.CW(CW), .WIN_BITS(WIN_BITS)) u_bound (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .hit        (hit),
        .frame_en   (frame_en),
        .multi_mode (multi_mode),
        .win_next   (win_next),
        .char_out   (char_out),
        .char_stb   (char_stb),
        .realign    (realign)
    );

endmodule

// File: tb/sim_sbf_framer.sv
module sim_sbf_framer;

    localparam logic [9:0] KP  = 10'b0011111010;
    localparam logic [9:0] KN  = 10'b1100000101;
    localparam logic [9:0] DA  = 10'b1010101010;
    localparam logic [9:0] DB  = 10'b0101010101;
    localparam logic [9:0] C7X = 10'b0011111110;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       frame_en = 1'b1;
    logic       multi_mode = 1'b0;
    logic       full_pat = 1'b1;
    logic [9:0] char_out;
    logic       char_stb;
    logic       realign;

    int total = 0;
    int bad = 0;
    int n_stb = 0;
    int n_rl = 0;
    int n_idle_stb = 0;
    logic [9:0] last_char = '0;
    logic stb_last = 1'b0;
    logic rl_last = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    sbf_framer u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .frame_en(frame_en), .multi_mode(multi_mode), .full_pat(full_pat),
        .char_out(char_out), .char_stb(char_stb), .realign(realign)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        n_stb = 0; n_rl = 0; n_idle_stb = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(posedge clk);
        #5;
        stb_last = char_stb;
        rl_last  = realign;
        if (char_stb) begin
            n_stb++;
            last_char = char_out;
        end
        if (realign) n_rl++;
    endtask

    task automatic send_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_en = 1'b0;
            @(posedge clk);
            #5;
            if (char_stb) n_idle_stb++;
        end
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 9; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R1 char_out", 32'(char_out), 32'h0);
        chk("R1 char_stb", 32'(char_stb), 32'h0);
        chk("R1 realign", 32'(realign), 32'h0);
    endtask

    task automatic t_single();
        multi_mode = 1'b0; full_pat = 1'b1; clr();
        send_zeros(3);
        send_word(KP);
        chk("R5 realign pulse", 32'(rl_last), 32'h1);
        chk("R5 strobe with comma", 32'(stb_last), 32'h1);
        chk("R5 comma char", 32'(last_char), 32'(KP));
        chk("R5 one realign", 32'(n_rl), 32'h1);
        clr();
        send_word(DA);
        chk("R2 strobe after ten bits", 32'(stb_last), 32'h1);
        chk("R2 char order", 32'(last_char), 32'(DA));
        chk("R2 one strobe", 32'(n_stb), 32'h1);
    endtask

    task automatic t_aligned();
        clr();
        send_word(KN);
        chk("R6 no realign", 32'(n_rl), 32'h0);
        chk("R6 strobe kept", 32'(stb_last), 32'h1);
        chk("R4 negative comma char", 32'(last_char), 32'(KN));
    endtask

    task automatic t_patterns();
        full_pat = 1'b1; clr();
        send_bit(1'b0); send_bit(1'b1);
        send_word(C7X);
        chk("R4 partial comma ignored", 32'(n_rl), 32'h0);
        chk("R4 boundary held", 32'(last_char), 32'h13F);
        full_pat = 1'b0; clr();
        send_word(C7X);
        chk("R3 short comma realign", 32'(n_rl), 32'h1);
        chk("R3 short comma char", 32'(last_char), 32'(C7X));
        full_pat = 1'b1;
    endtask

    task automatic t_gaps();
        clr();
        for (int i = 9; i >= 0; i--) begin
            send_bit(DA[i]);
            send_idle(2);
        end
        for (int i = 9; i >= 0; i--) begin
            send_bit(DB[i]);
            send_idle(1);
        end
        chk("R2 strobes per 20 bits", 32'(n_stb), 32'h2);
        chk("R2 no idle strobes", 32'(n_idle_stb), 32'h0);
        chk("R2 char after gaps", 32'(last_char), 32'(DB));
        chk("R2 no realign", 32'(n_rl), 32'h0);
    endtask

    task automatic t_multi_accept();
        multi_mode = 1'b1; clr();
        send_zeros(3);
        send_word(KP);
        chk("R7 first candidate quiet", 32'(n_rl), 32'h0);
        send_word(DA); send_word(DA); send_word(DA);
        send_word(KP);
        chk("R7 second at 40 accepted", 32'(n_rl), 32'h1);
        chk("R7 realign on second", 32'(rl_last), 32'h1);
        chk("R7 comma char", 32'(last_char), 32'(KP));
    endtask

    task automatic t_multi_expire();
        clr();
        send_zeros(3);
        send_word(KP);
        for (int k = 0; k < 4; k++) send_word(DA);
        send_word(KP);
        chk("R8 second at 50 rejected", 32'(n_rl), 32'h0);
        send_word(KP);
        chk("R8 fresh candidate accepted", 32'(n_rl), 32'h1);
    endtask

    task automatic t_disabled();
        multi_mode = 1'b0; frame_en = 1'b0; clr();
        send_zeros(3);
        send_word(KP);
        chk("R9 no realign", 32'(n_rl), 32'h0);
        chk("R9 old boundary", 32'(last_char), 32'h01F);
        chk("R9 one strobe", 32'(n_stb), 32'h1);
        frame_en = 1'b1;
    endtask

    task automatic t_multi_phase();
        multi_mode = 1'b1; clr();
        send_zeros(2);
        send_word(KP);
        send_zeros(1);
        send_word(KP);
        chk("R7 other alignment quiet", 32'(n_rl), 32'h0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_aligned();
        t_patterns();
        t_gaps();
        t_multi_accept();
        t_multi_expire();
        t_disabled();
        t_multi_phase();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule